// File: doc/BRIEF.md
# Receive descriptor ring writer

This block is the receive half of an Ethernet MAC. It places incoming frames into memory through a circular list of buffer descriptors that software sets up. Each descriptor takes eight bytes. The first word holds the buffer address, and its two lowest bits carry flags: bit 0 marks the buffer as holding a frame, which makes it owned by software, and bit 1 marks the last descriptor of the list. The second word receives the frame length. Software loads the list origin through a base-pointer write. Frames arrive as a byte stream with a last-byte marker. The block fetches the current descriptor, writes the frame bytes one byte lane at a time, writes the length, and then hands the descriptor to software by setting its ownership bit.

A sticky three-bit status register reports what happened. Bit 0 is frame stored, bit 1 is overrun and bit 2 is no buffer available. Software clears a bit by writing a one to it. The interrupt line is high while any bit is set. When the next descriptor is still owned, the block keeps re-reading that descriptor until software clears the ownership bit. A frame that cannot be placed is dropped whole.

Top module: `rxd_ring_writer`

## Requirements
- R1: After reset, the status reads 0 and irq is low. No memory read or write is made until the first base-pointer write.
- R2: A base write (base_wr) makes the block read the descriptor address word at exactly base_addr in the next cycle. base_addr must be 8-byte aligned.
- R3: Byte i of a stored frame is written to the address (address word with bits 1:0 cleared) + i. The byte is placed on lane addr[1:0] with a single byte enable, and a memory read never coincides with a write.
- R4: After the last byte, the word at descriptor+4 is written with the stored length in bits 10:0. That length counts every byte received, including the 4-byte FCS.
- R5: The descriptor's address word is rewritten with bit 0 (owned) set and all other bits kept. This happens in the cycle right after the length word is written, so it is the last write of the frame.
- R6: After a frame, the next descriptor is 8 bytes further on. If bit 1 (wrap) of the used descriptor is set, the next descriptor is the one at the base.
- R7: If a frame starts while the current descriptor has bit 0 set, the frame is dropped with no memory write and status bit 2 is set. The block then re-reads the descriptor until software clears bit 0.
- R8: A frame that starts before the next descriptor has been fetched is dropped and sets status bit 1. This covers the four cycles after a stored frame's last byte, and the time just after a base write.
- R9: A frame longer than BUF_BYTES has only its first BUF_BYTES bytes stored. Its length word reads BUF_BYTES, and both status bit 1 and status bit 0 are set.
- R10: Status bit 0 (frame stored) is set by the ownership write of each stored frame.
- R11: A write with clr_wr clears only the status bits that are one in clr_mask. A bit being set in the same cycle stays set. irq is high exactly when any status bit is one.
- R12: A frame arriving before any base write is dropped and sets status bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_wr | input | 1 | Load the descriptor list origin |
| base_addr | input | 32 | Byte address of the first descriptor |
| in_valid | input | 1 | Frame byte present |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | This byte ends the frame |
| clr_wr | input | 1 | Status clear strobe |
| clr_mask | input | 3 | Ones clear the matching status bits |
| status | output | 3 | {no buffer, overrun, frame stored} |
| irq | output | 1 | High while any status bit is set |
| mem_rd | output | 1 | Word read request |
| mem_wr | output | 1 | Write request |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte enables |
| mem_rdata | input | 32 | Read data, valid the cycle after mem_rd |

## Verification
A byte sampled at a clock edge is written to memory in that same cycle. The length word follows one cycle after the last byte, and the ownership word one cycle after that. The status bits for a stored frame appear after the ownership cycle; those for a drop appear one edge after the dropped frame's first byte. The next frame can be accepted five cycles after the last byte. The bench drives inputs on falling edges and counts those edges before each check, always sampling on a falling edge. The clear-during-set case is timed to land exactly in the ownership cycle, and the gap case starts a frame on the first edge after a last byte.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

    localparam int WORD_W   = 32;
    localparam int OWN_BIT  = 0;
    localparam int WRAP_BIT = 1;
    localparam int DESC_STEP = 8;

    typedef enum logic [2:0] {
        S_OFF,
        S_FETCH,
        S_WAIT,
        S_IDLE,
        S_RECV,
        S_STAT,
        S_OWN
    } ring_state_e;

    typedef struct packed {
        logic nobuf;
        logic ovrun;
        logic done;
    } rx_flags_t;

    function automatic logic [3:0] lane_of(input logic [1:0] low);
        return 4'b0001 << low;
    endfunction

    function automatic logic [WORD_W-1:0] buf_of(input logic [WORD_W-1:0] word);
        return {word[WORD_W-1:2], 2'b00};
    endfunction

endpackage

// File: rtl/rxd_frame_track.sv
module rxd_frame_track (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic in_last,
    output logic start
);
    logic inside_q;

    assign start = in_valid && !inside_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            inside_q <= 1'b0;
        end else if (in_valid) begin
            inside_q <= !in_last;
        end
    end
endmodule

// File: rtl/rxd_status.sv
module rxd_status
    import rxd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  rx_flags_t set_f,
    input  logic      clr_wr,
    input  logic [2:0] clr_mask,
    output logic [2:0] status,
    output logic      irq
);
    logic [2:0] flags_q;
    logic [2:0] clr_bits;

    assign clr_bits = clr_wr ? clr_mask : 3'b000;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= 3'b000;
        end else begin
            flags_q <= (flags_q & ~clr_bits) | set_f;
        end
    end

    assign status = flags_q;
    assign irq    = |flags_q;
endmodule

// File: rtl/rxd_ring_fsm.sv
module rxd_ring_fsm
    import rxd_pkg::*;
#(
    parameter int BUF_BYTES = 1536,
    parameter int LEN_W     = $clog2(BUF_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              base_wr,
    input  logic [WORD_W-1:0] base_addr,
    input  logic              start,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              in_last,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic [3:0]        mem_be,
    input  logic [WORD_W-1:0] mem_rdata,
    output rx_flags_t         set_f
);
    localparam logic [LEN_W-1:0] LIMIT = LEN_W'(BUF_BYTES);

    ring_state_e       state_q;
    logic [WORD_W-1:0] base_q;
    logic [WORD_W-1:0] ptr_q;
    logic [WORD_W-1:0] desc_q;
    logic [LEN_W-1:0]  cnt_q;
    logic              trunc_q;
    logic              unavail_q;

    logic              accept;
    logic              drop;
    logic [WORD_W-1:0] byte_addr;

    assign accept    = (state_q == S_IDLE) && !desc_q[OWN_BIT];
    assign drop      = start && !accept;
    assign byte_addr = buf_of(desc_q) + WORD_W'(cnt_q);

    always_comb begin
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = ptr_q;
        mem_wdata = '0;
        mem_be    = 4'b0000;
        set_f     = '0;
        case (state_q)
            S_FETCH: mem_rd = 1'b1;
            S_IDLE: begin
                if (start && accept) begin
                    mem_wr    = 1'b1;
                    mem_addr  = buf_of(desc_q);
                    mem_wdata = {4{in_data}};
                    mem_be    = lane_of(mem_addr[1:0]);
                end
            end
            S_RECV: begin
                if (in_valid && (cnt_q < LIMIT)) begin
                    mem_wr    = 1'b1;
                    mem_addr  = byte_addr;
                    mem_wdata = {4{in_data}};
                    mem_be    = lane_of(byte_addr[1:0]);
                end
            end
            S_STAT: begin
                mem_wr    = 1'b1;
                mem_addr  = ptr_q + WORD_W'(4);
                mem_wdata = WORD_W'(cnt_q);
                mem_be    = 4'hF;
            end
            S_OWN: begin
                mem_wr    = 1'b1;
                mem_wdata = desc_q | WORD_W'(1 << OWN_BIT);
                mem_be    = 4'hF;
                set_f.done  = 1'b1;
                set_f.ovrun = trunc_q;
            end
            default: ;
        endcase
        if (drop) begin
            if (unavail_q) set_f.nobuf = 1'b1;
            else           set_f.ovrun = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= S_OFF;
            base_q    <= '0;
            ptr_q     <= '0;
            desc_q    <= '0;
            cnt_q     <= '0;
            trunc_q   <= 1'b0;
            unavail_q <= 1'b1;
        end else if (base_wr) begin
            base_q    <= base_addr;
            ptr_q     <= base_addr;
            unavail_q <= 1'b0;
            state_q   <= S_FETCH;
        end else begin
            case (state_q)
                S_FETCH: state_q <= S_WAIT;
                S_WAIT: begin
                    desc_q    <= mem_rdata;
                    unavail_q <= mem_rdata[OWN_BIT];
                    state_q   <= S_IDLE;
                end
                S_IDLE: begin
                    if (start && accept) begin
                        cnt_q   <= LEN_W'(1);
                        trunc_q <= 1'b0;
                        state_q <= in_last ? S_STAT : S_RECV;
                    end else if (desc_q[OWN_BIT]) begin
                        state_q <= S_FETCH;
                    end
                end
                S_RECV: begin
                    if (in_valid) begin
                        if (cnt_q < LIMIT) cnt_q   <= cnt_q + LEN_W'(1);
                        else               trunc_q <= 1'b1;
                        if (in_last)       state_q <= S_STAT;
                    end
                end
                S_STAT: state_q <= S_OWN;
                S_OWN: begin
                    ptr_q     <= desc_q[WRAP_BIT] ? base_q : ptr_q + WORD_W'(DESC_STEP);
                    unavail_q <= 1'b0;
                    state_q   <= S_FETCH;
                end
                default: state_q <= state_q;
            endcase
        end
    end
endmodule

// File: rtl/rxd_ring_writer.sv
module rxd_ring_writer
    import rxd_pkg::*;
#(
    parameter int BUF_BYTES = 1536
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        base_wr,
    input  logic [31:0] base_addr,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    input  logic        in_last,
    input  logic        clr_wr,
    input  logic [2:0]  clr_mask,
    output logic [2:0]  status,
    output logic        irq,
    output logic        mem_rd,
    output logic        mem_wr,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    output logic [3:0]  mem_be,
    input  logic [31:0] mem_rdata
);
    localparam int LEN_W = $clog2(BUF_BYTES + 1);

    logic      start;
    rx_flags_t set_f;

    rxd_frame_track u_track (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_last  (in_last),
        .start    (start)
    );

    rxd_ring_fsm #(
        .BUF_BYTES (BUF_BYTES),
        .LEN_W     (LEN_W)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .base_wr   (base_wr),
        .base_addr (base_addr),
        .start     (start),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_last   (in_last),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_be    (mem_be),
        .mem_rdata (mem_rdata),
        .set_f     (set_f)
    );

    rxd_status u_status (
        .clk      (clk),
        .rst      (rst),
        .set_f    (set_f),
        .clr_wr   (clr_wr),
        .clr_mask (clr_mask),
        .status   (status),
        .irq      (irq)
    );
endmodule

// File: rtl/rxd_ring_writer_chk.sv
module rxd_ring_writer_chk (
    input logic        clk,
    input logic        rst,
    input logic        base_wr,
    input logic [31:0] base_addr,
    input logic [2:0]  status,
    input logic        mem_rd,
    input logic        mem_wr,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic [3:0]  mem_be
);
    // R2
    base_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        base_wr |=> (mem_rd && mem_addr == $past(base_addr)));

    // R3
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    // R3
    lane_shape_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> ($countones(mem_be) == 1 || mem_be == 4'hF));

    // R5
    own_after_len_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && mem_be == 4'hF && !mem_addr[2]) |->
            (mem_wdata[0] && $past(mem_wr) && $past(mem_be) == 4'hF
             && $past(mem_addr) == mem_addr + 32'd4));

    // R10
    done_needs_own_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(status[0]) |-> $past(mem_wr && mem_be == 4'hF && !mem_addr[2]));
endmodule

bind rxd_ring_writer rxd_ring_writer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .base_wr   (base_wr),
    .base_addr (base_addr),
    .status    (status),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_be    (mem_be)
);

// File: tb/rxd_ring_writer_test.sv
module rxd_ring_writer_test;
    localparam int BUF = 1536;
    localparam logic [31:0] RING = 32'h3800;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        base_wr = 1'b0;
    logic [31:0] base_addr = '0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_last = 1'b0;
    logic        clr_wr = 1'b0;
    logic [2:0]  clr_mask = '0;
    logic [2:0]  status;
    logic        irq;
    logic        mem_rd, mem_wr;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [3:0]  mem_be;

    int tests = 0;
    int fails = 0;
    int wr_count = 0;
    int order_err = 0;
    logic [31:0] prev_addr = '0;
    logic        prev_word = 1'b0;

    logic [31:0] mem [0:4095];

    always #4 clk = ~clk;

    rxd_ring_writer #(.BUF_BYTES(BUF)) uut (
        .clk(clk), .rst(rst), .base_wr(base_wr), .base_addr(base_addr),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .clr_wr(clr_wr), .clr_mask(clr_mask), .status(status), .irq(irq),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr[13:2]];
        if (mem_wr) begin
            wr_count <= wr_count + 1;
            for (int b = 0; b < 4; b++)
                if (mem_be[b]) mem[mem_addr[13:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
            if (mem_be == 4'hF && !mem_addr[2] && !(prev_word && prev_addr == mem_addr + 32'd4))
                order_err <= order_err + 1;
        end
        prev_word <= mem_wr && mem_be == 4'hF;
        prev_addr <= mem_addr;
    end

    function automatic logic [7:0] rd_byte(input logic [31:0] a);
        return mem[a[13:2]][8*a[1:0] +: 8];
    endfunction

    function automatic logic [31:0] rd_word(input logic [31:0] a);
        return mem[a[13:2]];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic send_frame(input int len, input logic [7:0] seed);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = seed + 8'(i);
            in_last  = (i == len - 1);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_last  = 1'b0;
            clr_wr   = 1'b0;
        end
    endtask

    task automatic clear(input logic [2:0] m);
        @(negedge clk);
        in_valid = 1'b0;
        clr_wr   = 1'b1;
        clr_mask = m;
        @(negedge clk);
        clr_wr   = 1'b0;
    endtask

    task automatic bytes_ok(input string req, input logic [31:0] b, input int len, input logic [7:0] seed);
        int bad = 0;
        for (int i = 0; i < len; i++)
            if (rd_byte(b + 32'(i)) !== seed + 8'(i)) bad++;
        check(req, 32'(bad), 32'd0);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 status", {29'd0, status}, 32'd0);
        check("R1 irq", {31'd0, irq}, 32'd0);
        check("R1 no access", {30'd0, mem_rd, mem_wr}, 32'd0);
    endtask

    task automatic t_no_base;
        int w0 = wr_count;
        send_frame(10, 8'h10);
        idle(3);
        check("R12 nobuf", {29'd0, status}, 32'b100);
        check("R12 no write", 32'(wr_count - w0), 32'd0);
        check("R11 irq set", {31'd0, irq}, 32'd1);
        clear(3'b111);
        check("R11 cleared", {29'd0, status}, 32'd0);
        check("R11 irq low", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_base_fetch;
        for (int k = 0; k < 8; k++) begin
            mem[(RING[13:2]) + 12'(2 * k)]     = 32'(k * BUF) | ((k == 7) ? 32'd2 : 32'd0);
            mem[(RING[13:2]) + 12'(2 * k + 1)] = 32'd0;
        end
        @(negedge clk);
        base_wr = 1'b1;
        base_addr = RING;
        @(negedge clk);
        base_wr = 1'b0;
        check("R2 read issued", {31'd0, mem_rd}, 32'd1);
        check("R2 read addr", mem_addr, RING);
        idle(4);
    endtask

    task automatic t_first_frame;
        send_frame(20, 8'h40);
        idle(1);
        @(negedge clk);
        clr_wr = 1'b1;
        clr_mask = 3'b001;
        @(negedge clk);
        clr_wr = 1'b0;
        check("R11 set wins", {29'd0, status}, 32'b001);
        check("R10 done", {31'd0, status[0]}, 32'd1);
        idle(4);
        bytes_ok("R3 bytes", 32'h0, 20, 8'h40);
        check("R4 length", rd_word(RING + 4), 32'd20);
        check("R5 owned", rd_word(RING), 32'h1);
        check("R5 order", 32'(order_err), 32'd0);
    endtask

    task automatic t_back_to_back;
        clear(3'b111);
        send_frame(33, 8'h80);
        send_frame(7, 8'hC0);
        idle(8);
        check("R6 next desc", rd_word(RING + 8), 32'h601);
        check("R4 length B", rd_word(RING + 12), 32'd33);
        bytes_ok("R3 bytes B", 32'h600, 33, 8'h80);
        check("R8 dropped", {24'd0, rd_byte(32'hC00)}, 32'd0);
        check("R8 overrun", {29'd0, status}, 32'b011);
    endtask

    task automatic t_fill_wrap;
        for (int k = 2; k < 8; k++) begin
            send_frame(4 + k, 8'(k * 16));
            idle(8);
        end
        check("R6 desc2", rd_word(RING + 16), 32'hC01);
        check("R6 wrap kept", rd_word(RING + 56), 32'h2A03);
        check("R4 length 7", rd_word(RING + 60), 32'd11);
        clear(3'b111);
        send_frame(9, 8'h22);
        idle(8);
        check("R7 nobuf", {29'd0, status}, 32'b100);
        check("R7 buffer kept", {24'd0, rd_byte(32'h0)}, 32'h40);
        check("R7 length kept", rd_word(RING + 4), 32'd20);
    endtask

    task automatic t_truncate;
        mem[RING[13:2]] = 32'h0;
        idle(8);
        clear(3'b111);
        send_frame(BUF + 4, 8'h01);
        idle(8);
        check("R9 length cap", rd_word(RING + 4), 32'(BUF));
        check("R9 flags", {29'd0, status}, 32'b011);
        check("R9 next buffer intact", {24'd0, rd_byte(32'h600)}, 32'h80);
        check("R9 last kept byte", {24'd0, rd_byte(32'(BUF - 1))}, 32'(8'(1 + BUF - 1)));
        check("R6 wrapped to base", rd_word(RING), 32'h1);
        check("R5 order all", 32'(order_err), 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 32'd0;
        t_reset;
        t_no_base;
        t_base_fetch;
        t_first_frame;
        t_back_to_back;
        t_fill_wrap;
        t_truncate;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule